// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block resolves load-linked / store-conditional atomic sequences for a cache that several requesters share. Each completed operation arrives as one strobe that carries an operation kind, a line address and a requester ID. A load-linked opens a reservation for that requester on that line. A store-conditional asks whether that reservation is still held. An ordinary store from the reserving requester, or an external invalidate or eviction of the line, cancels it. The block does not hold cache tags. The cache supplies a line-present qualifier with each operation and reports invalidates on a separate input.

Reservations sit in a small table of entries. Each requester holds at most one entry. When the table is full, a new requester's load-linked takes the entry that was allocated longest ago. A bypass input switches reservation handling off, so the operation reports success and leaves the table alone. Separately, a locked read-modify-write read raises a blocked flag for its line, and the matching locked write lowers it.

The response is registered. It appears one cycle after the operation strobe, as a valid bit and a success bit.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (opKind 0) returns success 1 and reserves its line for the issuing requester.
- R2: A store-conditional (opKind 1) returns success 1 only when the same requester holds a reservation on that line, and returns 0 otherwise. Only a store-conditional can return 0.
- R3: Every operation strobe gives rspValid high exactly one cycle later. Operations other than store-conditional return success 1.
- R4: Every store-conditional clears all reservations on its line, whether it succeeds or fails, including those of other requesters.
- R5: An ordinary store (opKind 2) with linePresent high, from a requester that holds a reservation on that line, clears all reservations on that line.
- R6: An ordinary store with linePresent low, or from a requester without a reservation on that line, leaves reservations unchanged.
- R7: With bypass high, an operation returns success 1 and neither sets nor clears any reservation.
- R8: A locked read (opKind 3) sets lineBlocked and blockedLine on the next cycle. A locked write (opKind 4) to the blocked line clears lineBlocked. A locked write to any other line leaves it set.
- R9: An invalidate clears all reservations on invLine at the same clock edge. A store-conditional to that line in the same cycle fails. A load-linked to that line in the same cycle still leaves its own reservation in place.
- R10: A load-linked by a requester that already holds a reservation moves that reservation to the new line, so the old line is no longer reserved for it.
- R11: A load-linked from a requester with no entry, when every entry is in use, replaces the entry that was allocated or refreshed longest ago.
- R12: opKind values 5, 6 and 7 are plain reads. They return success 1 and change no reservation.
- R13: After reset, rspValid and lineBlocked are 0 and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | A completed operation is presented this cycle |
| opKind | input | 3 | 0 load-linked, 1 store-conditional, 2 store, 3 locked read, 4 locked write, 5..7 plain read |
| opLine | input | LINE_W | Line address of the operation |
| opReqId | input | ID_W | Requester issuing the operation |
| linePresent | input | 1 | The line is present in the cache (qualifies ordinary stores) |
| bypass | input | 1 | Skip reservation handling and report success |
| invValid | input | 1 | Invalidate or eviction of invLine this cycle |
| invLine | input | LINE_W | Line being invalidated |
| rspValid | output | 1 | Response for the previous cycle's operation |
| rspSuccess | output | 1 | Success flag: 1 pass, 0 store-conditional failure |
| lineBlocked | output | 1 | A locked read-modify-write holds a line |
| blockedLine | output | LINE_W | Line held by the locked sequence |

## Verification
An invalidate and an operation on the same line can arrive in the same cycle. Their ordering decides whether a reservation survives. The bench provokes this by driving invValid together with a store-conditional on the reserved line, which must fail. It also drives invValid together with a load-linked on the line, whose reservation must still let a later store-conditional pass. A final case invalidates a different line, and that reservation must be untouched.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [2:0] {
    OP_LL      = 3'd0,
    OP_SC      = 3'd1,
    OP_STORE   = 3'd2,
    OP_LOCK_RD = 3'd3,
    OP_LOCK_WR = 3'd4,
    OP_LOAD    = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } opKind_e;

  // Strobes from control to the reservation datapath.
  typedef struct packed {
    logic setResv;      // allocate/refresh the requester's entry on opLine
    logic clearLine;    // drop every entry holding opLine
    logic invClear;     // drop every entry holding invLine
    logic lockSet;      // mark opLine blocked
    logic lockRelease;  // unblock if opLine is the blocked line
  } tblStrobe_t;

endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic [LINE_W-1:0] opLine,
  input  logic              linePresent,
  input  logic              bypass,
  input  logic              invValid,
  input  logic [LINE_W-1:0] invLine,
  input  logic              resvHit,
  output tblStrobe_t        strobe,
  output logic              rspValid,
  output logic              rspSuccess
);

  opKind_e kind;
  logic    isLL, isSC, isStore, isLockRd, isLockWr;
  logic    invSameLine;
  logic    scPass;

  assign kind        = opKind_e'(opKind);
  assign isLL        = (kind == OP_LL);
  assign isSC        = (kind == OP_SC);
  assign isStore     = (kind == OP_STORE);
  assign isLockRd    = (kind == OP_LOCK_RD);
  assign isLockWr    = (kind == OP_LOCK_WR);
  assign invSameLine = invValid && (invLine == opLine);

  // An invalidate landing in the same cycle beats the store-conditional.
  assign scPass = bypass || (resvHit && !invSameLine);

  always_comb begin
    strobe             = '0;
    strobe.setResv     = opValid && isLL && !bypass;
    strobe.clearLine   = opValid && !bypass &&
                         (isSC || (isStore && linePresent && resvHit));
    strobe.invClear    = invValid;
    strobe.lockSet     = opValid && isLockRd;
    strobe.lockRelease = opValid && isLockWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspSuccess <= 1'b0;
    end else begin
      rspValid   <= opValid;
      rspSuccess <= opValid && (isSC ? scPass : 1'b1);
    end
  end

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && bypass) |=> (rspValid && rspSuccess)); // R7

  AST_FAIL_ONLY_SC: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspSuccess) |-> ($past(opKind) == 3'd1 && !$past(bypass))); // R2

  AST_SC_INV_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isSC && invSameLine && !bypass) |=> !rspSuccess); // R9

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  parameter int ID_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblStrobe_t        strobe,
  input  logic [LINE_W-1:0] opLine,
  input  logic [ID_W-1:0]   opReqId,
  input  logic [LINE_W-1:0] invLine,
  output logic              resvHit,
  output logic              lineBlocked,
  output logic [LINE_W-1:0] blockedLine
);

  logic [ENTRIES-1:0]              entValid;
  logic [LINE_W-1:0]               entLine [ENTRIES];
  logic [ID_W-1:0]                 entId   [ENTRIES];
  // olderRow[i][j] set: entry i was allocated before entry j.
  logic [ENTRIES-1:0][ENTRIES-1:0] olderRow;

  logic [ENTRIES-1:0] hitVec, ownVec, freeVec, victimVec, firstFree, allocVec;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_match
    logic [ENTRIES-1:0] selfBit;
    assign selfBit       = ENTRIES'(1) << gi;
    assign hitVec[gi]    = entValid[gi] && entLine[gi] == opLine && entId[gi] == opReqId;
    assign ownVec[gi]    = entValid[gi] && entId[gi] == opReqId;
    assign victimVec[gi] = &(olderRow[gi] | selfBit);
  end

  assign resvHit   = |hitVec;
  assign freeVec   = ~entValid;
  assign firstFree = freeVec & (~freeVec + ENTRIES'(1));

  always_comb begin
    if (|ownVec)       allocVec = ownVec;
    else if (|freeVec) allocVec = firstFree;
    else               allocVec = victimVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entLine[i] <= '0;
        entId[i]   <= '0;
        for (int j = 0; j < ENTRIES; j++) olderRow[i][j] <= (i < j);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.setResv && allocVec[i]) begin
          entValid[i] <= 1'b1;
          entLine[i]  <= opLine;
          entId[i]    <= opReqId;
        end else if ((strobe.clearLine && entLine[i] == opLine) ||
                     (strobe.invClear && entLine[i] == invLine)) begin
          entValid[i] <= 1'b0;
        end
        if (strobe.setResv) begin
          for (int j = 0; j < ENTRIES; j++) begin
            if (allocVec[i])      olderRow[i][j] <= 1'b0;
            else if (allocVec[j]) olderRow[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineBlocked <= 1'b0;
      blockedLine <= '0;
    end else if (strobe.lockSet) begin
      lineBlocked <= 1'b1;
      blockedLine <= opLine;
    end else if (strobe.lockRelease && lineBlocked && blockedLine == opLine) begin
      lineBlocked <= 1'b0;
    end
  end

  // ---- checking support ----
  function automatic logic lineHeld(input logic [LINE_W-1:0] ln);
    logic r;
    r = 1'b0;
    for (int i = 0; i < ENTRIES; i++) r = r | (entValid[i] && entLine[i] == ln);
    return r;
  endfunction

  logic dupId;
  always_comb begin
    dupId = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (entValid[i] && entValid[j] && entId[i] == entId[j]) dupId = 1'b1;
  end

  logic              clrChk, invChk;
  logic [LINE_W-1:0] clrChkLine, invChkLine;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrChk     <= 1'b0;
      invChk     <= 1'b0;
      clrChkLine <= '0;
      invChkLine <= '0;
    end else begin
      clrChk     <= strobe.clearLine;
      clrChkLine <= opLine;
      invChk     <= strobe.invClear && !(strobe.setResv && opLine == invLine);
      invChkLine <= invLine;
    end
  end

  AST_ONE_PER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !dupId); // R10

  AST_LINE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    clrChk |-> !lineHeld(clrChkLine)); // R4

  AST_INV_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    invChk |-> !lineHeld(invChkLine)); // R9

  AST_BLOCK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lockRelease && !strobe.lockSet && lineBlocked && blockedLine == opLine)
      |=> !lineBlocked); // R8

  AST_BLOCK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockSet |=> (lineBlocked && blockedLine == $past(opLine))); // R8

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  parameter int ID_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic [LINE_W-1:0] opLine,
  input  logic [ID_W-1:0]   opReqId,
  input  logic              linePresent,
  input  logic              bypass,
  input  logic              invValid,
  input  logic [LINE_W-1:0] invLine,
  output logic              rspValid,
  output logic              rspSuccess,
  output logic              lineBlocked,
  output logic [LINE_W-1:0] blockedLine
);

  tblStrobe_t strobe;
  logic       resvHit;

  llsc_ctrl #(.LINE_W(LINE_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .opKind      (opKind),
    .opLine      (opLine),
    .linePresent (linePresent),
    .bypass      (bypass),
    .invValid    (invValid),
    .invLine     (invLine),
    .resvHit     (resvHit),
    .strobe      (strobe),
    .rspValid    (rspValid),
    .rspSuccess  (rspSuccess)
  );

  llsc_resv_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W)) i_table (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .opLine      (opLine),
    .opReqId     (opReqId),
    .invLine     (invLine),
    .resvHit     (resvHit),
    .lineBlocked (lineBlocked),
    .blockedLine (blockedLine)
  );

endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 4;
  localparam int LINE_W     = 26;
  localparam int ID_W       = 3;

  localparam logic [2:0] K_LL = 3'd0, K_SC = 3'd1, K_ST = 3'd2,
                         K_LRD = 3'd3, K_LWR = 3'd4, K_LD = 3'd5;

  logic              clk = 1'b0;
  logic              rstN;
  logic              opValid;
  logic [2:0]        opKind;
  logic [LINE_W-1:0] opLine;
  logic [ID_W-1:0]   opReqId;
  logic              linePresent;
  logic              bypass;
  logic              invValid;
  logic [LINE_W-1:0] invLine;
  logic              rspValid;
  logic              rspSuccess;
  logic              lineBlocked;
  logic [LINE_W-1:0] blockedLine;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 0;
  logic lastValid, lastOk;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W)) i_llsc_monitor (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opLine(opLine),
    .opReqId(opReqId), .linePresent(linePresent), .bypass(bypass),
    .invValid(invValid), .invLine(invLine), .rspValid(rspValid),
    .rspSuccess(rspSuccess), .lineBlocked(lineBlocked), .blockedLine(blockedLine)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, sample the response at the next one.
  task automatic op(input logic [2:0] k, input int ln, input int id,
                    input logic pres = 1'b1, input logic byp = 1'b0,
                    input logic inv = 1'b0, input int invL = 0);
    @(negedge clk);
    opValid     = 1'b1;
    opKind      = k;
    opLine      = LINE_W'(ln);
    opReqId     = ID_W'(id);
    linePresent = pres;
    bypass      = byp;
    invValid    = inv;
    invLine     = LINE_W'(invL);
    @(negedge clk);
    lastValid   = rspValid;
    lastOk      = rspSuccess;
    opValid     = 1'b0;
    invValid    = 1'b0;
    bypass      = 1'b0;
  endtask

  task automatic tReset;
    chk("R13 rspValid after reset", 32'(rspValid), 0);
    chk("R13 lineBlocked after reset", 32'(lineBlocked), 0);
    op(K_SC, 5, 0);
    chk("R13 no reservation after reset", 32'(lastOk), 0);
  endtask

  task automatic tLlSc;
    op(K_LL, 10, 1);
    chk("R1 load-linked success", 32'(lastOk), 1);
    chk("R3 rspValid one cycle later", 32'(lastValid), 1);
    @(negedge clk);
    chk("R3 rspValid drops with no op", 32'(rspValid), 0);
    op(K_SC, 10, 1);
    chk("R2 SC after LL succeeds", 32'(lastOk), 1);
    op(K_SC, 10, 1);
    chk("R4 second SC fails", 32'(lastOk), 0);
  endtask

  task automatic tScOther;
    op(K_LL, 20, 1);
    op(K_SC, 20, 2);
    chk("R2 SC by other requester fails", 32'(lastOk), 0);
    op(K_SC, 20, 1);
    chk("R4 failed SC cleared line", 32'(lastOk), 0);
  endtask

  task automatic tSharedLine;
    op(K_LL, 30, 1);
    op(K_LL, 30, 2);
    op(K_SC, 30, 1);
    chk("R2 SC holder on shared line", 32'(lastOk), 1);
    op(K_SC, 30, 2);
    chk("R4 SC clears other requester", 32'(lastOk), 0);
  endtask

  task automatic tStore;
    op(K_LL, 40, 3);
    op(K_ST, 40, 3, 1'b0);
    chk("R3 store returns success", 32'(lastOk), 1);
    op(K_SC, 40, 3);
    chk("R6 store with line absent keeps reservation", 32'(lastOk), 1);
    op(K_LL, 41, 3);
    op(K_ST, 41, 4, 1'b1);
    op(K_SC, 41, 3);
    chk("R6 store by other requester keeps reservation", 32'(lastOk), 1);
    op(K_LL, 42, 3);
    op(K_ST, 42, 3, 1'b1);
    op(K_SC, 42, 3);
    chk("R5 own store clears reservation", 32'(lastOk), 0);
  endtask

  task automatic tBypass;
    op(K_LL, 50, 1);
    op(K_SC, 50, 2, 1'b1, 1'b1);
    chk("R7 bypass SC reports success", 32'(lastOk), 1);
    op(K_SC, 50, 1);
    chk("R7 bypass SC left reservation", 32'(lastOk), 1);
    op(K_LL, 51, 1, 1'b1, 1'b1);
    chk("R7 bypass LL success", 32'(lastOk), 1);
    op(K_SC, 51, 1);
    chk("R7 bypass LL reserved nothing", 32'(lastOk), 0);
  endtask

  task automatic tMove;
    op(K_LL, 60, 5);
    op(K_LL, 61, 5);
    op(K_SC, 60, 5);
    chk("R10 old line released", 32'(lastOk), 0);
    op(K_SC, 61, 5);
    chk("R10 new line reserved", 32'(lastOk), 1);
  endtask

  task automatic tFull;
    for (int i = 0; i < 4; i++) op(K_LL, 70 + i, i);
    op(K_LL, 70, 0);          // refresh requester 0: requester 1 now oldest
    op(K_LL, 74, 4);          // table full: evicts requester 1
    op(K_SC, 71, 1);
    chk("R11 oldest entry evicted", 32'(lastOk), 0);
    op(K_SC, 70, 0);
    chk("R11 refreshed entry kept", 32'(lastOk), 1);
    op(K_SC, 74, 4);
    chk("R11 new requester reserved", 32'(lastOk), 1);
    op(K_SC, 72, 2);
    chk("R11 requester 2 kept", 32'(lastOk), 1);
    op(K_SC, 73, 3);
    chk("R11 requester 3 kept", 32'(lastOk), 1);
  endtask

  task automatic tInv;
    op(K_LL, 80, 1);
    op(K_LD, 80, 1, 1'b1, 1'b0, 1'b1, 80);
    chk("R12 plain read success", 32'(lastOk), 1);
    op(K_SC, 80, 1);
    chk("R9 invalidate clears reservation", 32'(lastOk), 0);
    op(K_LL, 81, 2);
    op(K_SC, 81, 2, 1'b1, 1'b0, 1'b1, 81);
    chk("R9 SC with same-cycle invalidate fails", 32'(lastOk), 0);
    op(K_LL, 82, 2, 1'b1, 1'b0, 1'b1, 82);
    op(K_SC, 82, 2);
    chk("R9 LL survives same-cycle invalidate", 32'(lastOk), 1);
    op(K_LL, 83, 3);
    op(K_LD, 0, 3, 1'b1, 1'b0, 1'b1, 84);
    op(K_SC, 83, 3);
    chk("R9 invalidate of other line ignored", 32'(lastOk), 1);
  endtask

  task automatic tKinds;
    op(K_LL, 90, 6);
    op(3'd7, 90, 6);
    chk("R12 kind 7 success", 32'(lastOk), 1);
    op(3'd6, 90, 6);
    op(K_SC, 90, 6);
    chk("R12 kinds 6/7 leave reservation", 32'(lastOk), 1);
  endtask

  task automatic tLock;
    op(K_LRD, 100, 2);
    chk("R8 locked read blocks", 32'(lineBlocked), 1);
    chk("R8 blocked line value", 32'(blockedLine), 100);
    op(K_LWR, 101, 2);
    chk("R8 other-line write keeps block", 32'(lineBlocked), 1);
    op(K_LWR, 100, 2);
    chk("R8 matching write releases", 32'(lineBlocked), 0);
  endtask

  initial begin
    rstN = 1'b0; opValid = 1'b0; opKind = '0; opLine = '0; opReqId = '0;
    linePresent = 1'b0; bypass = 1'b0; invValid = 1'b0; invLine = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset;
    tLlSc;
    tScOther;
    tSharedLine;
    tStore;
    tBypass;
    tMove;
    tFull;
    tInv;
    tKinds;
    tLock;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule